// File: doc/BRIEF.md
# Reorder Buffer with Reserved Gap

This block is a circular reorder buffer for a core that fetches control-independent work early. Entries can finish executing in any order, but they retire only in program order, one per cycle. Each entry carries a small payload that is handed back when the entry retires.

A protected branch is allocated together with a predicted gap size. The buffer puts the branch in one slot and keeps the next slots empty as reserved holes. Work past the reconvergence point is allocated after those holes. Control-dependent work that arrives later fills the holes in order, through a separate fill port. The size is only a prediction, so two things can happen. If the control-dependent work needs more slots than were reserved, everything after the branch is discarded and a flush pulse is raised. If it needs fewer, closing the gap turns the unused holes into no-ops that retire without doing anything.

While a gap is open, nothing behind the protected branch retires. Only one gap can be open at a time. Reserved holes count against capacity exactly like real entries.

Top module: `gap_rob`

## Requirements
- R1: After reset the buffer is empty: `commit_valid` is 0, `flush` is 0, `alloc_idx` is 0 and `alloc_ready` is 1 for an ordinary request.
- R2: An entry retires only when it is the oldest entry and has been marked complete through `done_valid`/`done_idx`. A completed younger entry waits behind an incomplete older one. Retirement happens at most once per cycle, in allocation order.
- R3: `alloc_idx` gives the slot number that the next accepted allocation takes. A protected branch accepted at slot b with gap size g takes slot b, reserves slots b+1 to b+g, and the next allocation goes to slot b+g+1.
- R4: Each accepted `fill_valid` writes `fill_data` into the lowest reserved slot not yet written. Filled entries retire in slot order, between the branch and the entries after the gap.
- R5: A request needs 1 slot if ordinary and 1+g slots if protected. `alloc_ready` is 0 whenever fewer free slots remain than the request needs. Reserved holes count as occupied.
- R6: While a gap is open, the slot right after the protected branch does not retire, even if it is marked complete.
- R7: A fill arriving when every reserved slot of the open gap is already used is an overflow. In that cycle `alloc_ready` is 0. On the next cycle `flush` is 1 for exactly one cycle, `alloc_idx` equals the branch slot plus one, and no entry younger than the branch ever retires.
- R8: A `gap_close` pulse closes the open gap. Each reserved slot still unwritten then retires without a completion mark, with `commit_nop` = 1.
- R9: While a gap is open, a protected request is refused (`alloc_ready` = 0), but an ordinary request with room is accepted.
- R10: `fill_valid` while no gap is open changes nothing: no slot is taken and nothing retires.
- R11: A protected branch with gap size 0 reserves no slot, and its first fill is an overflow.
- R12: Slot numbers wrap from DEPTH-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_prot | input | 1 | Request is a protected branch |
| alloc_gap | input | GW | Predicted gap size for a protected request |
| alloc_data | input | DW | Payload of the allocated entry |
| alloc_ready | output | 1 | Request can be accepted this cycle |
| alloc_idx | output | log2(DEPTH) | Slot number the next allocation takes |
| fill_valid | input | 1 | Control-dependent entry for the open gap |
| fill_data | input | DW | Payload of the gap fill |
| gap_close | input | 1 | Close the open gap |
| done_valid | input | 1 | Mark an entry complete |
| done_idx | input | log2(DEPTH) | Slot to mark complete |
| commit_valid | output | 1 | Oldest entry retires this cycle |
| commit_data | output | DW | Payload of the retiring entry |
| commit_nop | output | 1 | Retiring entry is an unused gap slot |
| flush | output | 1 | One-cycle pulse after a gap overflow |

## Verification
The bench builds the block with its default parameters: 32 slots, a 4-bit gap size and an 8-bit payload. At that depth, a gap of 15 followed by sixteen ordinary entries fills the buffer exactly. That sequence exercises the full-buffer stall, the sizing boundary of a maximal protected request, and slot numbers wrapping from 31 to 0 within one run. Smaller gaps, including a zero gap, reach both the overflow flush and the no-op retirement of holes that were never filled.

// File: rtl/grob_pkg.sv
package grob_pkg;

    localparam int ROB_DEPTH = 32;
    localparam int PAY_W     = 8;
    localparam int GAP_W     = 4;

    // Per-slot state: written, finished, retires as nothing.
    typedef struct packed {
        logic filled;
        logic done;
        logic nop;
    } slot_flags_t;

    function automatic slot_flags_t slot_mark(input logic f, input logic d, input logic n);
        return '{filled: f, done: d, nop: n};
    endfunction

endpackage

// File: rtl/grob_gap_ctl.sv
module grob_gap_ctl #(
    parameter int IW = 5,
    parameter int GW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          open_req,
    input  logic [IW-1:0] open_base,
    input  logic [GW-1:0] open_len,
    input  logic          fill_req,
    input  logic          close_req,
    output logic          gap_open,
    output logic [IW-1:0] gap_base,
    output logic [IW-1:0] fill_slot,
    output logic [GW-1:0] fill_left,
    output logic          fill_fire,
    output logic          ovf_fire,
    output logic          close_fire
);

    assign close_fire = gap_open && close_req;
    assign fill_fire  = gap_open && fill_req && !close_req && (fill_left != '0);
    assign ovf_fire   = gap_open && fill_req && !close_req && (fill_left == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_open  <= 1'b0;
            gap_base  <= '0;
            fill_slot <= '0;
            fill_left <= '0;
        end else if (open_req) begin
            gap_open  <= 1'b1;
            gap_base  <= open_base;
            fill_slot <= open_base + IW'(1);
            fill_left <= open_len;
        end else if (close_fire || ovf_fire) begin
            gap_open  <= 1'b0;
        end else if (fill_fire) begin
            fill_slot <= fill_slot + IW'(1);
            fill_left <= fill_left - GW'(1);
        end
    end

    AST_GAP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        open_req |-> !gap_open) else $error("second gap opened"); // R9

endmodule

// File: rtl/grob_store.sv
module grob_store
    import grob_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    parameter int GW    = 4,
    parameter int IW    = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          alloc_we,
    input  logic [IW-1:0] alloc_at,
    input  logic [DW-1:0] alloc_data,
    input  logic [GW-1:0] alloc_holes,
    input  logic          done_we,
    input  logic [IW-1:0] done_at,
    input  logic          fill_we,
    input  logic [IW-1:0] fill_at,
    input  logic [DW-1:0] fill_data,
    input  logic          close_we,
    input  logic [IW-1:0] close_from,
    input  logic [GW-1:0] close_len,
    input  logic [IW-1:0] head_at,
    output logic          head_ok,
    output logic          head_nop,
    output logic [DW-1:0] head_data
);

    slot_flags_t   flags [DEPTH];
    logic [DW-1:0] pay   [DEPTH];
    logic [DEPTH-1:0] hole_hit;
    logic [DEPTH-1:0] nop_hit;

    // Window decode per slot: reserved behind a new branch, or left empty at close.
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        logic [IW-1:0] rel_alloc;
        logic [IW-1:0] rel_close;
        assign rel_alloc   = IW'(s) - alloc_at - IW'(1);
        assign rel_close   = IW'(s) - close_from;
        assign hole_hit[s] = alloc_we && (rel_alloc < IW'(alloc_holes));
        assign nop_hit[s]  = close_we && (rel_close < IW'(close_len));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) flags[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (done_we && done_at == IW'(i) && flags[i].filled)
                    flags[i].done <= 1'b1;
                if (alloc_we && alloc_at == IW'(i))
                    flags[i] <= slot_mark(1'b1, 1'b0, 1'b0);
                else if (hole_hit[i])
                    flags[i] <= slot_mark(1'b0, 1'b0, 1'b0);
                if (fill_we && fill_at == IW'(i))
                    flags[i] <= slot_mark(1'b1, 1'b0, 1'b0);
                if (nop_hit[i])
                    flags[i] <= slot_mark(1'b1, 1'b1, 1'b1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (alloc_we) pay[alloc_at] <= alloc_data;
        if (fill_we)  pay[fill_at]  <= fill_data;
    end

    assign head_ok   = flags[head_at].filled && flags[head_at].done;
    assign head_nop  = flags[head_at].nop;
    assign head_data = pay[head_at];

    AST_FILL_HOLE: assert property (@(posedge clk) disable iff (rst)
        fill_we |-> !flags[fill_at].filled) else $error("fill onto a written slot"); // R4

endmodule

// File: rtl/gap_rob.sv
module gap_rob #(
    parameter int DEPTH = grob_pkg::ROB_DEPTH,
    parameter int DW    = grob_pkg::PAY_W,
    parameter int GW    = grob_pkg::GAP_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     alloc_valid,
    input  logic                     alloc_prot,
    input  logic [GW-1:0]            alloc_gap,
    input  logic [DW-1:0]            alloc_data,
    output logic                     alloc_ready,
    output logic [$clog2(DEPTH)-1:0] alloc_idx,
    input  logic                     fill_valid,
    input  logic [DW-1:0]            fill_data,
    input  logic                     gap_close,
    input  logic                     done_valid,
    input  logic [$clog2(DEPTH)-1:0] done_idx,
    output logic                     commit_valid,
    output logic [DW-1:0]            commit_data,
    output logic                     commit_nop,
    output logic                     flush
);

    localparam int IW = $clog2(DEPTH);
    localparam int CW = IW + 1;
    localparam logic [CW-1:0] CAP = CW'(DEPTH);

    logic [IW-1:0] head_q, tail_q;
    logic [CW-1:0] count_q;
    logic          flush_q;

    logic          gap_open, fill_fire, ovf_fire, close_fire;
    logic [IW-1:0] gap_base, fill_slot;
    logic [GW-1:0] fill_left;
    logic          head_ok, head_nop;
    logic [DW-1:0] head_data;

    logic [CW-1:0] need, room;
    logic          alloc_fire, retire;
    logic [IW-1:0] head_nx, after_branch;

    assign need         = alloc_prot ? CW'(alloc_gap) + CW'(1) : CW'(1);
    assign room         = CAP - count_q;
    assign alloc_ready  = (room >= need) && !(alloc_prot && gap_open) && !ovf_fire;
    assign alloc_fire   = alloc_valid && alloc_ready;
    assign after_branch = gap_base + IW'(1);
    // Nothing behind an open protected branch may leave.
    assign retire       = (count_q != '0) && head_ok && !(gap_open && head_q == after_branch);
    assign head_nx      = head_q + IW'(retire);

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
            flush_q <= 1'b0;
        end else begin
            flush_q <= ovf_fire;
            head_q  <= head_nx;
            if (ovf_fire) begin
                tail_q  <= after_branch;
                count_q <= {1'b0, after_branch - head_nx};
            end else begin
                if (alloc_fire) tail_q <= tail_q + need[IW-1:0];
                count_q <= count_q + (alloc_fire ? need : '0) - CW'(retire);
            end
        end
    end

    grob_gap_ctl #(.IW(IW), .GW(GW)) i_gap (
        .clk        (clk),
        .rst        (rst),
        .open_req   (alloc_fire && alloc_prot),
        .open_base  (tail_q),
        .open_len   (alloc_gap),
        .fill_req   (fill_valid),
        .close_req  (gap_close),
        .gap_open   (gap_open),
        .gap_base   (gap_base),
        .fill_slot  (fill_slot),
        .fill_left  (fill_left),
        .fill_fire  (fill_fire),
        .ovf_fire   (ovf_fire),
        .close_fire (close_fire)
    );

    grob_store #(.DEPTH(DEPTH), .DW(DW), .GW(GW), .IW(IW)) i_store (
        .clk         (clk),
        .rst         (rst),
        .alloc_we    (alloc_fire),
        .alloc_at    (tail_q),
        .alloc_data  (alloc_data),
        .alloc_holes (alloc_prot ? alloc_gap : '0),
        .done_we     (done_valid),
        .done_at     (done_idx),
        .fill_we     (fill_fire),
        .fill_at     (fill_slot),
        .fill_data   (fill_data),
        .close_we    (close_fire),
        .close_from  (fill_slot),
        .close_len   (fill_left),
        .head_at     (head_q),
        .head_ok     (head_ok),
        .head_nop    (head_nop),
        .head_data   (head_data)
    );

    assign alloc_idx    = tail_q;
    assign commit_valid = retire;
    assign commit_data  = head_data;
    assign commit_nop   = head_nop;
    assign flush        = flush_q;

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count_q <= CAP) else $error("occupancy above capacity"); // R5
    AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (rst)
        flush |=> !flush) else $error("flush longer than one cycle"); // R7
    AST_FLUSH_SHRINK: assert property (@(posedge clk) disable iff (rst)
        flush |-> count_q <= $past(count_q)) else $error("flush grew occupancy"); // R7

endmodule

// File: tb/test_gap_rob.sv
`timescale 1ns/1ps
module test_gap_rob;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       alloc_valid = 1'b0, alloc_prot = 1'b0;
    logic [3:0] alloc_gap = '0;
    logic [7:0] alloc_data = '0;
    logic       alloc_ready;
    logic [4:0] alloc_idx;
    logic       fill_valid = 1'b0;
    logic [7:0] fill_data = '0;
    logic       gap_close = 1'b0;
    logic       done_valid = 1'b0;
    logic [4:0] done_idx = '0;
    logic       commit_valid, commit_nop, flush;
    logic [7:0] commit_data;

    int nchk = 0, nbad = 0, nlog = 0;
    bit finished = 0;
    logic [7:0] log_d [64];
    logic       log_n [64];

    always #4 clk = ~clk;

    gap_rob i_gap_rob (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_prot(alloc_prot), .alloc_gap(alloc_gap),
        .alloc_data(alloc_data), .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
        .fill_valid(fill_valid), .fill_data(fill_data), .gap_close(gap_close),
        .done_valid(done_valid), .done_idx(done_idx),
        .commit_valid(commit_valid), .commit_data(commit_data),
        .commit_nop(commit_nop), .flush(flush)
    );

    // Retirement log, sampled mid-cycle.
    always @(negedge clk) begin
        if (!rst && commit_valid && nlog < 64) begin
            log_d[nlog] = commit_data;
            log_n[nlog] = commit_nop;
            nlog++;
        end
    end

    // prot, gap, data, expected ready, expected slot
    localparam logic [18:0] TBL [6] = '{
        {1'b0, 4'd0, 8'h10, 1'b1, 5'd0},
        {1'b0, 4'd0, 8'h11, 1'b1, 5'd1},
        {1'b1, 4'd3, 8'h12, 1'b1, 5'd2},
        {1'b0, 4'd0, 8'h13, 1'b1, 5'd6},
        {1'b1, 4'd2, 8'h99, 1'b0, 5'd7},
        {1'b0, 4'd0, 8'h14, 1'b1, 5'd7}
    };

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic alloc(input logic p, input logic [3:0] g, input logic [7:0] d,
                         input logic [4:0] exp_idx, input string tag);
        alloc_valid = 1'b1; alloc_prot = p; alloc_gap = g; alloc_data = d; #1;
        chk(tag, alloc_idx, exp_idx);
        tick();
        alloc_valid = 1'b0; alloc_prot = 1'b0; alloc_gap = '0;
    endtask

    task automatic mark(input logic [4:0] idx);
        done_valid = 1'b1; done_idx = idx; tick(); done_valid = 1'b0;
    endtask

    task automatic fill(input logic [7:0] d);
        fill_valid = 1'b1; fill_data = d; tick(); fill_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        nchk++; nbad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        idle(3);
        rst = 1'b0;
        #1;
        chk("R1 ready", alloc_ready, 1);
        chk("R1 idx", alloc_idx, 0);
        chk("R1 commit", commit_valid, 0);
        chk("R1 flush", flush, 0);

        // Table walk: ordinary, protected gap 3, post-gap, refused second gap (R9).
        for (int v = 0; v < 6; v++) begin
            alloc_valid = 1'b1; alloc_prot = TBL[v][18]; alloc_gap = TBL[v][17:14];
            alloc_data = TBL[v][13:6]; #1;
            chk("R3/R9 table ready", alloc_ready, TBL[v][5]);
            chk("R3 table idx", alloc_idx, TBL[v][4:0]);
            tick();
        end
        alloc_valid = 1'b0; alloc_prot = 1'b0;

        // R2: younger ones complete, oldest does not.
        mark(6); mark(7); mark(2); mark(1);
        idle(4);
        chk("R2 no retire before oldest", nlog, 0);
        mark(0);
        idle(6);
        chk("R2 count", nlog, 3);
        chk("R2 order0", log_d[0], 8'h10);
        chk("R2 order1", log_d[1], 8'h11);
        chk("R2 order2", log_d[2], 8'h12);

        // R4/R6: fills go to slots 3,4; they stay while gap open.
        fill(8'hA0); fill(8'hA1);
        mark(3); mark(4);
        idle(6);
        chk("R6 stall while open", nlog, 3);
        gap_close = 1'b1; tick(); gap_close = 1'b0;
        idle(10);
        chk("R8 count", nlog, 8);
        chk("R4 fill0", log_d[3], 8'hA0);
        chk("R4 fill1", log_d[4], 8'hA1);
        chk("R8 nop flag", log_n[5], 1);
        chk("R8 real flag", log_n[4], 0);
        chk("R4 post gap0", log_d[6], 8'h13);
        chk("R4 post gap1", log_d[7], 8'h14);

        // R10: fill with no gap.
        fill(8'hEE);
        idle(3);
        chk("R10 idx", alloc_idx, 8);
        chk("R10 no retire", nlog, 8);
        chk("R10 no flush", flush, 0);

        // R7: overflow flush.
        alloc(1'b1, 4'd1, 8'h20, 5'd8, "R3 branch idx");
        alloc(1'b0, 4'd0, 8'h21, 5'd10, "R3 after gap 1");
        alloc(1'b0, 4'd0, 8'h22, 5'd11, "R3 after gap");
        mark(8);
        idle(3);
        chk("R2 branch retired", nlog, 9);
        fill(8'hB0);
        fill_valid = 1'b1; fill_data = 8'hB1; #1;
        chk("R7 ready low on overflow", alloc_ready, 0);
        tick(); fill_valid = 1'b0;
        chk("R7 flush high", flush, 1);
        chk("R7 tail reset", alloc_idx, 9);
        tick();
        chk("R7 flush one cycle", flush, 0);
        alloc(1'b0, 4'd0, 8'h23, 5'd9, "R7 realloc idx");
        mark(9); mark(10); mark(11);
        idle(5);
        chk("R7 count", nlog, 10);
        chk("R7 survivor", log_d[9], 8'h23);

        // R11: zero gap.
        alloc(1'b1, 4'd0, 8'h30, 5'd10, "R11 branch idx");
        fill(8'hC0);
        chk("R11 flush", flush, 1);
        chk("R11 idx", alloc_idx, 11);
        mark(10);
        idle(4);
        chk("R11 branch retires", log_d[10], 8'h30);

        // R5/R12: maximal gap, fill to capacity, wrap.
        alloc(1'b1, 4'd15, 8'h40, 5'd11, "R5 big branch");
        for (int k = 0; k < 16; k++) begin
            alloc_valid = 1'b1; alloc_data = 8'h50 + 8'(k); #1;
            if (k == 5) chk("R12 wrap idx", alloc_idx, 0);
            if (k == 15) chk("R5 last slot ready", alloc_ready, 1);
            tick();
        end
        #1;
        chk("R5 full refuses", alloc_ready, 0);
        alloc_valid = 1'b0;
        gap_close = 1'b1; tick(); gap_close = 1'b0;
        mark(11);
        idle(24);
        chk("R8 holes retired", nlog, 27);
        chk("R8 last hole nop", log_n[26], 1);
        alloc_prot = 1'b1; alloc_gap = 4'd15; #1;
        chk("R5 sixteen free", alloc_ready, 1);
        alloc_prot = 1'b0; alloc_gap = '0;
        alloc(1'b0, 4'd0, 8'h70, 5'd11, "R12 wrapped idx");
        alloc_prot = 1'b1; alloc_gap = 4'd15; #1;
        chk("R5 fifteen free", alloc_ready, 0);
        alloc_gap = 4'd14; #1;
        chk("R5 exact fit", alloc_ready, 1);
        alloc_prot = 1'b0; alloc_gap = '0;

        finish_run();
    end

endmodule